// File: doc/BRIEF.md
# Nonvolatile Wiper Store/Restore Sequencer

This block sits between a decoded command path and the wiper register of a digital potentiometer. It owns the wiper scratchpad value and a small register-file model of nonvolatile storage. Word 0 of that storage is the saved wiper setting and the remaining words hold user data. Out of reset, word 0 holds the midscale code and the wiper is refreshed from it automatically. Commands can write the wiper directly, restore it from word 0 with or without a busy indication, store the wiper or arbitrary data into storage, and read back either a stored word or the live wiper.

A store occupies a long, parameterised window of `STORE_CYCLES` clock cycles. A restore takes `RESTORE_CYCLES` cycles. An active-low `busy_n` pin shows the long or visible operations. A write-lock input refuses store commands and sets a sticky error flag. An asynchronous active-low preset pin forces the wiper to midscale while it is low. When the pin returns high, the wiper is reloaded from word 0.

Commands enter on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle and the synchronised preset pin is high. Readback data leaves on a valid/ready port. `rd_data` is held steady while `rd_valid` is high and `rd_ready` is low. No new command is taken until the read is consumed.

Top module: `nv_wiper_sequencer`

## Requirements
- R1: After reset the wiper equals midscale (1 << (DATA_W-1)) and storage word 0 reads back midscale. `busy_n` and `cmd_ready` are low for the RESTORE_CYCLES boot refresh.
- R2: Op code 7 (write wiper) sets `wiper` to `cmd_data` in the cycle after acceptance, and `busy_n` stays high.
- R3: Op code 1 (quiet restore) loads `wiper` from word 0 after RESTORE_CYCLES cycles, and `busy_n` stays high throughout.
- R4: Op code 2 (visible restore) loads `wiper` from word 0, and `busy_n` is low for exactly RESTORE_CYCLES cycles.
- R5: Op code 3 (store wiper) writes the wiper value seen at acceptance into word 0, and `busy_n` is low for exactly STORE_CYCLES cycles.
- R6: Op code 4 (store word) writes `cmd_data` into the word at `cmd_addr`, and `busy_n` is low for exactly STORE_CYCLES cycles.
- R7: A store (op 3 or 4) accepted while `wr_lock` is high leaves storage unchanged and keeps `busy_n` high. It raises `err_wp` in the next cycle, and `err_wp` then stays high until reset.
- R8: Op code 5 (read word) presents the word at `cmd_addr` on `rd_data` with `rd_valid` high, and `busy_n` is low while `rd_valid` is high.
- R9: Op code 6 (read wiper) presents the wiper value seen at acceptance on `rd_data`.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` holds its value.
- R11: While the preset pin is low (after a two-flop synchroniser), the wiper is midscale and `busy_n` is low. After the pin rises, the wiper is reloaded from word 0 with `busy_n` low until done.
- R12: `cmd_ready` is low during any restore, store, read or preset. When `cmd_ready` is high, `busy_n` is high and `rd_valid` is low. Op code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (models power-on) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Operation code (0 to 7) |
| cmd_addr | input | ADDR_W | Storage word address |
| cmd_data | input | DATA_W | Write data |
| rd_valid | output | 1 | Readback data offered |
| rd_ready | input | 1 | Readback consumer ready |
| rd_data | output | DATA_W | Readback word |
| preset_n | input | 1 | Asynchronous preset pin, active low |
| wr_lock | input | 1 | Write lock for storage |
| busy_n | output | 1 | Active-low busy/ready indication |
| wiper | output | DATA_W | Wiper scratchpad value |
| err_wp | output | 1 | Sticky refused-store flag |

## Verification
The assertions assume that `cmd_op`, `cmd_addr` and `cmd_data` stay constant while `cmd_valid` is high. They also assume that the preset pin changes only while the sequencer is idle, and that `rd_ready` is driven only while a read is pending. The bench issues each command at a falling edge once `cmd_ready` is seen high, and withdraws it after a single acceptance edge. It toggles the preset pin only after the previous operation has returned to idle. It raises `rd_ready` after a random number of stall cycles.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    OP_NOP           = 3'd0,
    OP_RESTORE_QUIET = 3'd1,
    OP_RESTORE_BUSY  = 3'd2,
    OP_STORE_WIPER   = 3'd3,
    OP_STORE_WORD    = 3'd4,
    OP_READ_WORD     = 3'd5,
    OP_READ_WIPER    = 3'd6,
    OP_WRITE_WIPER   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESTORE,
    ST_STORE,
    ST_READ,
    ST_PRESET
  } state_e;
endpackage

// File: rtl/nvseq_pin_sync.sv
module nvseq_pin_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], pin};
  end

  assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/nvseq_span_timer.sv
module nvseq_span_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          active;

  // Comes out of reset running, so the boot refresh is timed too.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == limit) active <= 1'b0;
      else              cnt    <= cnt + 1'b1;
    end
  end

  assign done = active && (cnt == limit);
endmodule

// File: rtl/nvseq_store_array.sv
module nvseq_store_array #(
  parameter int DATA_W    = 10,
  parameter int ADDR_W    = 4,
  parameter int NUM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] word0
);
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] FACTORY = (i == 0) ? MIDSCALE : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          words[i] <= FACTORY;
      else if (we && int'(waddr) == i)     words[i] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < NUM_WORDS) ? words[raddr] : '0;
  assign word0 = words[0];
endmodule

// File: rtl/nv_wiper_sequencer.sv
module nv_wiper_sequencer
  import nvseq_pkg::*;
#(
  parameter int DATA_W         = 10,
  parameter int ADDR_W         = 4,
  parameter int NUM_WORDS      = 16,
  parameter int STORE_CYCLES   = 2500000,
  parameter int RESTORE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              preset_n,
  input  logic              wr_lock,
  output logic              busy_n,
  output logic [DATA_W-1:0] wiper,
  output logic              err_wp
);
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
  localparam int SPAN = (STORE_CYCLES > RESTORE_CYCLES) ? STORE_CYCLES : RESTORE_CYCLES;
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] STORE_LIM   = CW'(STORE_CYCLES - 1);
  localparam logic [CW-1:0] RESTORE_LIM = CW'(RESTORE_CYCLES - 1);

  state_e            state;
  logic              loud_q;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wiper_q;
  logic              err_q;
  logic              pre_s;
  logic              accept;
  logic              is_store;
  logic              tmr_start;
  logic              tmr_done;
  logic [CW-1:0]     tmr_limit;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] mem_word0;
  op_e               op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE) && pre_s;
  assign accept    = cmd_valid && cmd_ready;
  assign is_store  = (op == OP_STORE_WIPER) || (op == OP_STORE_WORD);

  assign tmr_start = (accept && (op == OP_RESTORE_QUIET || op == OP_RESTORE_BUSY ||
                                 (is_store && !wr_lock)))
                   || (state == ST_PRESET && pre_s);
  assign tmr_limit = (state == ST_STORE) ? STORE_LIM : RESTORE_LIM;
  assign mem_we    = (state == ST_STORE) && tmr_done;

  nvseq_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(preset_n), .pin_s(pre_s)
  );

  nvseq_span_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .limit(tmr_limit), .done(tmr_done)
  );

  nvseq_store_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(st_addr), .wdata(st_data),
    .raddr(cmd_addr), .rdata(mem_rdata), .word0(mem_word0)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESTORE;
      loud_q  <= 1'b1;
      wiper_q <= MIDSCALE;
      err_q   <= 1'b0;
      rd_q    <= '0;
      st_addr <= '0;
      st_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!pre_s) begin
            state   <= ST_PRESET;
            wiper_q <= MIDSCALE;
          end else if (cmd_valid) begin
            unique case (op)
              OP_WRITE_WIPER:   wiper_q <= cmd_data;
              OP_RESTORE_QUIET: begin state <= ST_RESTORE; loud_q <= 1'b0; end
              OP_RESTORE_BUSY:  begin state <= ST_RESTORE; loud_q <= 1'b1; end
              OP_STORE_WIPER, OP_STORE_WORD: begin
                if (wr_lock) err_q <= 1'b1;
                else begin
                  state   <= ST_STORE;
                  st_addr <= (op == OP_STORE_WORD) ? cmd_addr : '0;
                  st_data <= (op == OP_STORE_WORD) ? cmd_data : wiper_q;
                end
              end
              OP_READ_WORD:  begin state <= ST_READ; rd_q <= mem_rdata; end
              OP_READ_WIPER: begin state <= ST_READ; rd_q <= wiper_q; end
              default: ;
            endcase
          end
        end
        ST_RESTORE: if (tmr_done) begin
          wiper_q <= mem_word0;
          state   <= ST_IDLE;
        end
        ST_STORE: if (tmr_done) state <= ST_IDLE;
        ST_READ:  if (rd_ready) state <= ST_IDLE;
        ST_PRESET: begin
          wiper_q <= MIDSCALE;
          if (pre_s) begin
            state  <= ST_RESTORE;
            loud_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (state == ST_READ);
  assign rd_data  = rd_q;
  assign wiper    = wiper_q;
  assign err_wp   = err_q;
  assign busy_n   = !((state == ST_STORE) || (state == ST_READ) || (state == ST_PRESET) ||
                      (state == ST_RESTORE && loud_q));
endmodule

// File: rtl/nvseq_chk.sv
module nvseq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_lock,
  input logic              busy_n,
  input logic [DATA_W-1:0] wiper,
  input logic              err_wp
);
  // R2
  wiper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd7) |=> (wiper == $past(cmd_data)) && busy_n);

  // R3
  quiet_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1) |=> busy_n && !cmd_ready);

  // R7
  locked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && wr_lock && (cmd_op == 3'd3 || cmd_op == 3'd4)) |=> busy_n && err_wp);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_wp |=> err_wp);

  // R8
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy_n);

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data));

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> busy_n && !rd_valid);
endmodule

bind nv_wiper_sequencer nvseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .wr_lock(wr_lock), .busy_n(busy_n), .wiper(wiper), .err_wp(err_wp)
);

// File: tb/tb_nv_wiper_sequencer.sv
`timescale 1ns/1ps
module tb_nv_wiper_sequencer;
  localparam int DW = 10;
  localparam int AW = 4;
  localparam int NW = 16;
  localparam int SC = 40;
  localparam int RC = 2;
  localparam logic [DW-1:0] MID = 10'd512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic preset_n = 1'b1;
  logic wr_lock = 1'b0;
  logic busy_n;
  logic [DW-1:0] wiper;
  logic err_wp;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_mem [NW];
  logic [DW-1:0] m_wiper;
  logic m_err;

  always #5 clk = ~clk;

  nv_wiper_sequencer #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW),
                       .STORE_CYCLES(SC), .RESTORE_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .preset_n(preset_n), .wr_lock(wr_lock), .busy_n(busy_n),
    .wiper(wiper), .err_wp(err_wp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int exp_busy(input logic [2:0] op, input logic lock, input int stall);
    case (op)
      3'd2:       return RC;
      3'd3, 3'd4: return lock ? 0 : SC;
      3'd5, 3'd6: return stall + 1;
      default:    return 0;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic lock, input int stall);
    int busy_cnt = 0;
    int guard = 0;
    int stalls = 0;
    logic [DW-1:0] exp_rd;
    logic [DW-1:0] last_rd;
    @(negedge clk);
    while (!cmd_ready && guard < 1000) begin @(negedge clk); guard++; end
    exp_rd = (op == 3'd5) ? m_mem[a] : m_wiper;
    cmd_op = op; cmd_addr = a; cmd_data = d; wr_lock = lock; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_lock = 1'b0;
    if (op == 3'd7) chk("R2 wiper after write", int'(wiper), int'(d));
    if (op >= 3'd1 && op <= 3'd6 && !((op == 3'd3 || op == 3'd4) && lock))
      chk("R12 ready low during op", int'(cmd_ready), 0);
    if (op == 3'd0) chk("R12 nop keeps ready", int'(cmd_ready), 1);
    last_rd = '0;
    while (!cmd_ready && guard < 1000) begin
      if (!busy_n) busy_cnt++;
      if (rd_valid) begin
        if (stalls == 0)
          chk((op == 3'd5) ? "R8 read word" : "R9 read wiper", int'(rd_data), int'(exp_rd));
        else
          chk("R10 data held under stall", int'(rd_data), int'(last_rd));
        last_rd = rd_data;
        rd_ready = (stalls >= stall);
        stalls++;
      end
      @(negedge clk);
      guard++;
    end
    rd_ready = 1'b0;
    chk("watchdog per op", int'(guard < 1000), 1);
    case (op)
      3'd1: m_wiper = m_mem[0];
      3'd2: m_wiper = m_mem[0];
      3'd3: if (lock) m_err = 1'b1; else m_mem[0] = m_wiper;
      3'd4: if (lock) m_err = 1'b1; else m_mem[a] = d;
      3'd7: m_wiper = d;
      default: ;
    endcase
    case (op)
      3'd1: chk("R3 quiet restore busy", busy_cnt, 0);
      3'd2: chk("R4 visible restore busy", busy_cnt, RC);
      3'd3: chk(lock ? "R7 locked store busy" : "R5 store wiper busy", busy_cnt, exp_busy(op, lock, stall));
      3'd4: chk(lock ? "R7 locked store busy" : "R6 store word busy", busy_cnt, exp_busy(op, lock, stall));
      3'd5, 3'd6: chk("R8 busy while read pending", busy_cnt, exp_busy(op, lock, stall));
      default: chk("R2 no busy on write or nop", busy_cnt, 0);
    endcase
    chk("R3 wiper matches model", int'(wiper), int'(m_wiper));
    chk("R7 error flag", int'(err_wp), int'(m_err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    m_mem[0] = MID;
    m_wiper = MID;
    m_err = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy during boot refresh", int'(busy_n), 0);
    chk("R1 ready low during boot refresh", int'(cmd_ready), 0);
    cnt = 0;
    while (!cmd_ready && cnt < 50) begin @(negedge clk); cnt++; end
    chk("R1 boot refresh length", cnt, RC - 1);
    chk("R1 wiper midscale after reset", int'(wiper), int'(MID));
    chk("R1 error clear after reset", int'(err_wp), 0);
    run_op(3'd5, 4'd0, '0, 1'b0, 0);

    run_op(3'd0, 4'd3, 10'd77, 1'b0, 0);
    run_op(3'd7, 4'd0, 10'd1023, 1'b0, 0);
    run_op(3'd7, 4'd0, 10'd0, 1'b0, 0);
    run_op(3'd1, 4'd0, '0, 1'b0, 0);
    run_op(3'd7, 4'd0, 10'd100, 1'b0, 0);
    run_op(3'd3, 4'd0, '0, 1'b0, 0);
    run_op(3'd7, 4'd0, 10'd900, 1'b0, 0);
    run_op(3'd2, 4'd0, '0, 1'b0, 0);
    run_op(3'd4, 4'd15, 10'd345, 1'b0, 0);
    run_op(3'd5, 4'd15, '0, 1'b0, 5);
    run_op(3'd6, 4'd0, '0, 1'b0, 3);

    // R11 preset pin: midscale while low, reload from word 0 on release
    run_op(3'd7, 4'd0, 10'd900, 1'b0, 0);
    @(negedge clk);
    preset_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 wiper midscale while preset low", int'(wiper), int'(MID));
    chk("R11 busy while preset low", int'(busy_n), 0);
    chk("R12 ready low while preset low", int'(cmd_ready), 0);
    preset_n = 1'b1;
    cnt = 0;
    while (!cmd_ready && cnt < 50) begin
      if (busy_n) begin
        n_chk++; n_fail++;
        $display("FAIL R11 busy dropped during reload actual=%0d expected=%0d", 1, 0);
      end
      @(negedge clk); cnt++;
    end
    m_wiper = m_mem[0];
    chk("R11 wiper reloaded from word 0", int'(wiper), 100);

    // R7 write lock refuses both store kinds; flag stays set
    run_op(3'd4, 4'd7, 10'd222, 1'b1, 0);
    run_op(3'd5, 4'd7, '0, 1'b0, 0);
    run_op(3'd3, 4'd0, '0, 1'b1, 0);
    run_op(3'd5, 4'd0, '0, 1'b0, 1);
    run_op(3'd7, 4'd0, 10'd5, 1'b0, 0);

    for (int i = 0; i < 120; i++) begin
      logic [2:0] op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic lk;
      op = 3'($urandom_range(0, 7));
      a  = AW'($urandom_range(0, NW - 1));
      d  = DW'($urandom);
      lk = ($urandom_range(0, 3) == 0);
      run_op(op, a, d, lk, $urandom_range(0, 4));
    end
    for (int i = 0; i < NW; i++) run_op(3'd5, AW'(i), '0, 1'b0, 0);

    finish_run();
  end
endmodule